// File: doc/BRIEF.md
# Clock-Synchronous Single-Port RAM

This block is a single-port memory with active-low select and write controls. Every input is sampled on the rising edge of the clock: select, write, address and write data. When the select is sampled low, the block does one of two things. With the write control low, it stores the write data at the address and puts that same data on the output register. With the write control high, it loads the addressed word into the output register. When the select is sampled high, storage and output both stay as they are.

The output is write-through, so a write replaces whatever a previous read left on the output. The storage array is never cleared. The output register can be cleared by a synchronous active-high reset, and a parameter enables or disables that reset. The array and the output register are coded together so that a block RAM with a registered, write-first output can be inferred.

Top module: `sync_sp_ram`

## Requirements
- R1: Address width `ADDR_W` and data width `DATA_W` are parameters, and the array holds 2**`ADDR_W` words.
- R2: A rising edge with `sel_n` = 1 changes no stored word and leaves `rdata` unchanged, whatever `wr_n`, `addr` and `wdata` are.
- R3: A rising edge with `sel_n` = 0 and `wr_n` = 0 stores `wdata` into the word at `addr`.
- R4: After a rising edge with `sel_n` = 0 and `wr_n` = 0, `rdata` equals the `wdata` sampled at that edge.
- R5: After a rising edge with `sel_n` = 0 and `wr_n` = 1, `rdata` equals the word stored at the sampled `addr`.
- R6: A read of an address at the edge right after a write to that address returns the newly written data.
- R7: With `OUT_RST_EN` = 1, a rising edge with `rst` = 1 sets `rdata` to zero. Reset never alters stored words.
- R8: Input changes between rising edges have no effect on `rdata` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the output register |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write; high means read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data to store |
| rdata | output | DATA_W | Registered output: read word, or write data during a write |

## Verification
The hardest case to reach from the ports is proving that a deselected cycle carrying write-like inputs leaves storage untouched. The output alone cannot show this, because it holds its old value either way. The bench therefore drives deselected cycles with a low write control and fresh data at every address, then reads the whole array back and compares it with the reference model. The same read-back after a reset shows that reset clears only the output register. Write-then-read pairs at every address, and input changes made between clock edges, cover the same-address timing and the sampling behaviour.

// File: rtl/sync_sp_ram_pkg.sv
package sync_sp_ram_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ram_op_e;
endpackage

// File: rtl/sync_sp_ram_ctl.sv
module sync_sp_ram_ctl
  import sync_sp_ram_pkg::*;
(
  input  logic    sel_n,
  input  logic    wr_n,
  output ram_op_e op
);
  always_comb begin
    if (sel_n)      op = OP_HOLD;
    else if (!wr_n) op = OP_WRITE;
    else            op = OP_READ;
  end
endmodule

// File: rtl/sync_sp_ram_store.sv
module sync_sp_ram_store
  import sync_sp_ram_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter bit OUT_RST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  ram_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage: write port only, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (op == OP_WRITE) mem[addr] <= wdata;
  end

  // write-first output register with optional synchronous clear
  always_ff @(posedge clk) begin
    if (OUT_RST_EN && rst) q <= '0;
    else if (op == OP_WRITE) q <= wdata;
    else if (op == OP_READ) q <= mem[addr];
  end
endmodule

// File: rtl/sync_sp_ram.sv
module sync_sp_ram
  import sync_sp_ram_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter bit OUT_RST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  ram_op_e op;

  sync_sp_ram_ctl u_ctl (
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .op    (op)
  );

  sync_sp_ram_store #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .OUT_RST_EN (OUT_RST_EN)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .addr  (addr),
    .wdata (wdata),
    .q     (rdata)
  );
endmodule

// File: rtl/sync_sp_ram_chk.sv
module sync_sp_ram_chk #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter bit OUT_RST_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);
  // R2
  desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sel_n |=> $stable(rdata));

  // R4
  write_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n) |=> (rdata == $past(wdata)));

  // R6
  rd_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n) ##1 (!sel_n && wr_n && addr == $past(addr))
      |=> (rdata == $past(wdata, 2)));

  generate
    if (OUT_RST_EN) begin : g_rst
      // R7
      out_clear_chk: assert property (@(posedge clk)
        rst |=> (rdata == '0));
    end
  endgenerate
endmodule

bind sync_sp_ram sync_sp_ram_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .OUT_RST_EN (OUT_RST_EN)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .sel_n (sel_n),
  .wr_n  (wr_n),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata)
);

// File: tb/sync_sp_ram_bench.sv
module sync_sp_ram_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] refmem [int];
  logic [DW-1:0] exp_q;

  always #5 clk = ~clk;

  sync_sp_ram #(.ADDR_W(AW), .DATA_W(DW), .OUT_RST_EN(1'b1)) u_sync_sp_ram (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at negedge, apply one edge, update model, sample at next negedge
  task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string req);
    sel_n = s; wr_n = w; addr = a; wdata = d;
    @(posedge clk);
    if (!s) begin
      if (!w) begin refmem[a] = d; exp_q = d; end
      else exp_q = refmem[a];
    end
    @(negedge clk);
    check(req, rdata, exp_q);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + k * 101 + 5) ^ (k << 3));
  endfunction

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: rdata=%h expected=done", rdata);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_q = '0;
    repeat (3) @(negedge clk);
    check("R7 reset", rdata, '0);
    rst = 1'b0;

    // R3 R4: fill every word, output follows write data
    for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b0, AW'(a), pat(a, 1), "R4 write-through");
    // R5 R1: read back all 2**ADDR_W words
    for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, AW'(a), 'x, "R5 read");

    // R2: deselected cycles with write-like inputs change nothing
    for (int a = 0; a < DEPTH; a++) step(1'b1, 1'b0, AW'(a), ~pat(a, 1), "R2 hold");
    for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, AW'(a), '0, "R2 R3 storage untouched");

    // R6: write then read same address in next cycle
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b0, 1'b0, AW'(a), pat(a, 2), "R4 write-through");
      step(1'b0, 1'b1, AW'(a), '0, "R6 read after write");
    end

    // R8: input changes between edges do not reach the output
    for (int a = 0; a < 4; a++) begin
      step(1'b0, 1'b1, AW'(a), '0, "R5 read");
      sel_n = 1'b0; wr_n = 1'b0; addr = AW'(a + 5); wdata = 8'hA5;
      #2;
      check("R8 no async effect", rdata, exp_q);
      sel_n = 1'b1;
      #1;
      check("R8 no async effect", rdata, exp_q);
    end

    // random mix against the reference model
    for (int i = 0; i < 600; i++) begin
      logic s, w;
      s = ($urandom_range(0, 3) == 0);
      w = $urandom_range(0, 1);
      step(s, w, AW'($urandom), DW'($urandom), "R2 R3 R4 R5 random");
    end

    // R7: reset clears output but keeps storage
    sel_n = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R7 reset clears output", rdata, '0);
    rst = 1'b0; exp_q = '0;
    for (int a = 0; a < DEPTH; a++) step(1'b0, 1'b1, AW'(a), '0, "R7 storage kept");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule